// File: doc/BRIEF.md
# Single-Entry Decode-to-Execute Slot with Hazard Search

This block is a one-place holding slot placed between an instruction fetch/decode stage and an execute stage. The producer offers a decoded instruction record (an opaque payload plus a destination-register descriptor) through a valid/ready handshake. The consumer sees the held record on the head outputs and removes it with a dequeue strobe. A taken branch in the execute stage raises a clear input, which flushes the slot.

A combinational search port lets the upstream stage ask whether the held record still has to write a given register. The upstream stage uses the answer to stall on a read-after-write hazard. Within one cycle the operations take effect in a fixed order. Head access and dequeue come first, then search and enqueue, and clear is applied last. Because of this order the consumer can drain the slot while the producer refills it in the same cycle, which sustains one transfer per cycle. A record removed in a cycle is never reported by the search in that cycle.

Top module: `dslot_top`

## Requirements
- R1: After reset, head_valid and find_hit are 0 and enq_ready is 1.
- R2: When the slot is empty, enq_ready is 1. A record offered with enq_valid and no clear appears on the head outputs in the next cycle with head_valid 1.
- R3: When the slot is full and deq is 0, enq_ready is 0, and the held record and head_valid stay unchanged.
- R4: In a cycle where a full slot is dequeued while a new record is accepted, the head outputs still show the old record. The new record appears only in the next cycle.
- R5: When the slot is full and deq is 1, enq_ready is 1. A record offered in that cycle is held in the next cycle, so one record moves per cycle.
- R6: deq on a full slot with no accepted enqueue leaves the slot empty in the next cycle. deq is legal only while head_valid is 1.
- R7: find_hit is 1 when the slot is full, deq is 0, the held record has dst_vld 1, and its dst_idx equals find_idx.
- R8: find_hit is 0 in any cycle in which deq is 1.
- R9: find_hit is 0 when the held record has dst_vld 0, whatever find_idx is.
- R10: find_hit is 0 while the slot is empty, including the cycle in which a matching record is being enqueued.
- R11: clr empties the slot for the next cycle. If an enqueue handshake completes in the same cycle, that record is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Producer offers a record |
| enq_ready | output | 1 | Slot can take a record this cycle |
| enq_payload | input | PAYLOAD_W | Opaque record contents |
| enq_dst_vld | input | 1 | Record writes a destination register |
| enq_dst_idx | input | IDX_W | Destination register index |
| deq | input | 1 | Consumer removes the head record |
| clr | input | 1 | Flush on taken branch |
| head_valid | output | 1 | Slot holds a record |
| head_payload | output | PAYLOAD_W | Held record contents |
| head_dst_vld | output | 1 | Held record writes a register |
| head_dst_idx | output | IDX_W | Held record destination index |
| find_idx | input | IDX_W | Register index to search for |
| find_hit | output | 1 | Held record is a pending writer of find_idx |

## Verification
The assertions assume that the consumer never strobes deq while head_valid is 0. A dequeue on an empty slot is treated as a protocol error, not as a no-op. The stimulus keeps to this rule: the sweep builds each starting state first (empty, or full with a chosen descriptor), and it enables deq only for the full states. Every other input combination is driven freely, including clear together with enqueue and enqueue while the slot is full and not being drained. The search index is swept over all register indices inside each cycle.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

    // Occupancy state of the slot; extended as a struct so that the
    // next-state process can grow without touching the register process.
    typedef struct packed {
        logic full;
    } ctrl_state_t;

    localparam ctrl_state_t CTRL_RESET = '{full: 1'b0};

endpackage

// File: rtl/dslot_ctrl.sv
module dslot_ctrl
    import dslot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enq_valid,
    input  logic deq,
    input  logic clr,
    output logic full,
    output logic live,
    output logic enq_ready,
    output logic load_en
);

    ctrl_state_t state_d, state_q;
    logic        deq_eff;
    logic        enq_fire;

    always_comb begin
        state_d   = state_q;
        // head access and dequeue come first in the cycle
        deq_eff   = deq & state_q.full;
        live      = state_q.full & ~deq_eff;
        // search and enqueue see the slot after dequeue
        enq_ready = ~live;
        enq_fire  = enq_valid & enq_ready;
        // clear is applied last and overrides enqueue
        load_en   = enq_fire & ~clr;
        if (clr) begin
            state_d.full = 1'b0;
        end else if (enq_fire) begin
            state_d.full = 1'b1;
        end else begin
            state_d.full = live;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTRL_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign full = state_q.full;

    assert_deq_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        deq |-> state_q.full);

    assert_clear_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !state_q.full);

    assert_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enq_valid && enq_ready && !clr) |=> state_q.full);

    assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (deq && !enq_valid) |=> !state_q.full);

endmodule

// File: rtl/dslot_store.sv
module dslot_store #(
    parameter int PAYLOAD_W = 16,
    parameter int IDX_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_en,
    input  logic [PAYLOAD_W-1:0] in_payload,
    input  logic                 in_dst_vld,
    input  logic [IDX_W-1:0]     in_dst_idx,
    output logic [PAYLOAD_W-1:0] out_payload,
    output logic                 out_dst_vld,
    output logic [IDX_W-1:0]     out_dst_idx
);

    typedef struct packed {
        logic [PAYLOAD_W-1:0] payload;
        logic                 dst_vld;
        logic [IDX_W-1:0]     dst_idx;
    } entry_t;

    entry_t entry_d, entry_q;

    always_comb begin
        entry_d = entry_q;
        if (load_en) begin
            entry_d.payload = in_payload;
            entry_d.dst_vld = in_dst_vld;
            entry_d.dst_idx = in_dst_idx;
        end
    end

    // contents are meaningless while empty, so no reset is needed
    always_ff @(posedge clk) begin
        entry_q <= entry_d;
    end

    assign out_payload = entry_q.payload;
    assign out_dst_vld = entry_q.dst_vld;
    assign out_dst_idx = entry_q.dst_idx;

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(entry_q));

endmodule

// File: rtl/dslot_search.sv
module dslot_search #(
    parameter int IDX_W = 5
) (
    input  logic             live,
    input  logic             dst_vld,
    input  logic [IDX_W-1:0] dst_idx,
    input  logic [IDX_W-1:0] query,
    output logic             hit
);

    logic [IDX_W-1:0] bit_eq;

    for (genvar b = 0; b < IDX_W; b++) begin : g_cmp
        assign bit_eq[b] = ~(dst_idx[b] ^ query[b]);
    end

    always_comb begin
        hit = live & dst_vld & (&bit_eq);
    end

endmodule

// File: rtl/dslot_top.sv
module dslot_top #(
    parameter int PAYLOAD_W = 16,
    parameter int IDX_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enq_valid,
    output logic                 enq_ready,
    input  logic [PAYLOAD_W-1:0] enq_payload,
    input  logic                 enq_dst_vld,
    input  logic [IDX_W-1:0]     enq_dst_idx,
    input  logic                 deq,
    input  logic                 clr,
    output logic                 head_valid,
    output logic [PAYLOAD_W-1:0] head_payload,
    output logic                 head_dst_vld,
    output logic [IDX_W-1:0]     head_dst_idx,
    input  logic [IDX_W-1:0]     find_idx,
    output logic                 find_hit
);

    logic live;
    logic load_en;

    dslot_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_valid (enq_valid),
        .deq       (deq),
        .clr       (clr),
        .full      (head_valid),
        .live      (live),
        .enq_ready (enq_ready),
        .load_en   (load_en)
    );

    dslot_store #(.PAYLOAD_W(PAYLOAD_W), .IDX_W(IDX_W)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_en),
        .in_payload  (enq_payload),
        .in_dst_vld  (enq_dst_vld),
        .in_dst_idx  (enq_dst_idx),
        .out_payload (head_payload),
        .out_dst_vld (head_dst_vld),
        .out_dst_idx (head_dst_idx)
    );

    dslot_search #(.IDX_W(IDX_W)) u_search (
        .live    (live),
        .dst_vld (head_dst_vld),
        .dst_idx (head_dst_idx),
        .query   (find_idx),
        .hit     (find_hit)
    );

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !deq) |-> !enq_ready);

    assert_find_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        find_hit |-> (head_valid && !deq && head_dst_vld));

    assert_transfer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && deq && enq_valid && !clr) |=> (head_valid && head_payload == $past(enq_payload)));

endmodule

// File: tb/dslot_top_tb_top.sv
`timescale 1ns/1ps
module dslot_top_tb_top;

    localparam int PW = 16;
    localparam int IW = 5;
    localparam int NREG = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enq_valid = 1'b0;
    logic          enq_ready;
    logic [PW-1:0] enq_payload = '0;
    logic          enq_dst_vld = 1'b0;
    logic [IW-1:0] enq_dst_idx = '0;
    logic          deq = 1'b0;
    logic          clr = 1'b0;
    logic          head_valid;
    logic [PW-1:0] head_payload;
    logic          head_dst_vld;
    logic [IW-1:0] head_dst_idx;
    logic [IW-1:0] find_idx = '0;
    logic          find_hit;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // bench model of the slot
    bit            m_full = 1'b0;
    logic [PW-1:0] m_pay = '0;
    bit            m_vld = 1'b0;
    logic [IW-1:0] m_idx = '0;
    logic [PW-1:0] pay_ctr = 16'h1000;

    always #10 clk = ~clk;

    dslot_top #(.PAYLOAD_W(PW), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .enq_valid(enq_valid), .enq_ready(enq_ready),
        .enq_payload(enq_payload), .enq_dst_vld(enq_dst_vld), .enq_dst_idx(enq_dst_idx),
        .deq(deq), .clr(clr),
        .head_valid(head_valid), .head_payload(head_payload),
        .head_dst_vld(head_dst_vld), .head_dst_idx(head_dst_idx),
        .find_idx(find_idx), .find_hit(find_hit)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive at the falling edge, check combinational outputs
    // before the rising edge, then update the model at the rising edge.
    task automatic cycle(input bit ev, input bit dv, input logic [IW-1:0] di,
                         input bit dq, input bit cl);
        bit    rdy, fire;
        string tag;
        @(negedge clk);
        enq_valid   = ev;
        enq_dst_vld = dv;
        enq_dst_idx = di;
        enq_payload = pay_ctr;
        deq         = dq;
        clr         = cl;
        rdy  = !m_full || dq;
        fire = ev && rdy;
        #1;
        tag = m_full ? (dq ? "R5" : "R3") : "R2";
        check(enq_ready == rdy, tag, enq_ready, rdy);
        check(head_valid == m_full, "R3", head_valid, m_full);
        if (m_full) begin
            tag = (dq && fire) ? "R4" : "R3";
            check(head_payload == m_pay, tag, head_payload, m_pay);
        end
        for (int q = 0; q < NREG; q++) begin
            bit exp_hit;
            find_idx = q[IW-1:0];
            #0.2;
            exp_hit = m_full && !dq && m_vld && (m_idx == q[IW-1:0]);
            if (!m_full)    tag = "R10";
            else if (dq)    tag = "R8";
            else if (!m_vld) tag = "R9";
            else            tag = "R7";
            check(find_hit == exp_hit, tag, find_hit, exp_hit);
        end
        @(posedge clk);
        if (cl) begin
            m_full = 1'b0;
        end else if (fire) begin
            m_full = 1'b1;
            m_pay  = pay_ctr;
            m_vld  = dv;
            m_idx  = di;
        end else if (dq) begin
            m_full = 1'b0;
        end
        pay_ctr = pay_ctr + 16'h0101;
        @(negedge clk);
        enq_valid = 1'b0;
        deq = 1'b0;
        clr = 1'b0;
        #1;
        if (cl)        tag = "R11";
        else if (fire) tag = "R2";
        else if (dq)   tag = "R6";
        else           tag = "R3";
        check(head_valid == m_full, tag, head_valid, m_full);
        if (m_full) begin
            check(head_payload == m_pay, tag, head_payload, m_pay);
            check(head_dst_vld == m_vld, tag, head_dst_vld, m_vld);
            check(head_dst_idx == m_idx, tag, head_dst_idx, m_idx);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(head_valid == 1'b0, "R1", head_valid, 0);
        check(enq_ready == 1'b1, "R1", enq_ready, 1);
        check(find_hit == 1'b0, "R1", find_hit, 0);
        rst_n = 1'b1;

        // Sweep: start state x enq x deq (legal only if full) x clr x dst_vld
        for (int st = 0; st < 2; st++) begin
            for (int k = 0; k < 3; k++) begin
                for (int pv = 0; pv < 2; pv++) begin
                    for (int ev = 0; ev < 2; ev++) begin
                        for (int dq = 0; dq < 2; dq++) begin
                            for (int cl = 0; cl < 2; cl++) begin
                                for (int dv = 0; dv < 2; dv++) begin
                                    logic [IW-1:0] pidx;
                                    pidx = (k == 0) ? '0 : (k == 1) ? IW'(5) : '1;
                                    if (st == 0 && dq == 1) continue;
                                    // bring the slot to the start state
                                    cycle(1'b0, 1'b0, '0, 1'b0, 1'b1);
                                    if (st == 1) cycle(1'b1, pv[0], pidx, 1'b0, 1'b0);
                                    // cycle under test, new record targets a different index
                                    cycle(ev[0], dv[0], pidx ^ IW'(3), dq[0], cl[0]);
                                    // follow-up idle cycle checks search on the result
                                    cycle(1'b0, 1'b0, '0, 1'b0, 1'b0);
                                end
                            end
                        end
                    end
                end
            end
        end

        // back-to-back streaming, one transfer per cycle (R5)
        cycle(1'b0, 1'b0, '0, 1'b0, 1'b1);
        cycle(1'b1, 1'b1, IW'(1), 1'b0, 1'b0);
        for (int i = 2; i < 12; i++) begin
            cycle(1'b1, 1'b1, IW'(i), 1'b1, 1'b0);
        end
        cycle(1'b0, 1'b0, '0, 1'b1, 1'b0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule